// File: doc/BRIEF.md
# Descriptor Chain Walker for one DMA Channel

This block sequences one DMA channel through a chain of command descriptors held in memory. Software writes the address of the first descriptor into the head register and then writes the control word with the run and list bits set. The walker reads the eight-word descriptor at that address and copies its fields into the channel's working context. It then hands the byte count and the two addresses to a transfer datapath. When the datapath reports completion, the walker follows the descriptor's link word. A zero link ends the run. A link that points back into the chain makes the run repeat until software cancels it.

The sequencer has four states. IDLE waits for a start write. FETCH reads the descriptor words one at a time. LAUNCH pulses the datapath start for one cycle. WAIT waits for the datapath's done. The transitions are:
- start: IDLE to FETCH;
- last-word: FETCH to LAUNCH, once the eighth word is accepted;
- issue: LAUNCH to WAIT, unconditionally;
- follow: WAIT to FETCH, on done with a nonzero link;
- finish: WAIT to IDLE, on done with a zero link;
- abort: any state to IDLE, on a cancel write.

Two event pulses are raised. The loaded event marks the first launch of a run, after the list has been read in. The command event marks each completed command. Data movement itself is left to the datapath.

Top module: `dma_chain_walker`

## Requirements
- R1: While reset is held and just after it, mem_rd_req, xfer_start, evt_loaded and evt_cmd_done are all low.
- R2: A run fetches eight words from the node address N, at N, N+4, ..., N+28, in that order. The address moves to the next word only in a cycle where mem_rd_valid is high, and it is held otherwise.
- R3: Descriptor word 0 appears on xfer_gen_cfg, word 1 on xfer_port_cfg, word 2 on xfer_src and word 3 on xfer_dst.
- R4: xfer_bytes equals bits 23:0 of descriptor word 4 plus one, as a 25-bit value. Bits 31:24 of word 4 have no effect.
- R5: xfer_start is high for exactly one cycle after the eighth word is accepted. evt_loaded is high together with xfer_start on the first launch of a run only.
- R6: evt_cmd_done is high in the same cycle as xfer_done while a command is in flight (WAIT). xfer_done at any other time produces no event.
- R7: When a command completes and descriptor word 5 (the link) is nonzero, the next fetch starts at the link address.
- R8: When a command completes and the link is zero, the walker goes idle. It issues no further reads, and a later xfer_done produces no event.
- R9: A chain whose last link points back to an earlier descriptor repeats without end, and evt_loaded is raised only once in that run.
- R10: A write to offset 0x1C with bit 20 set cancels the run. Within one clock edge the walker is idle from any state: it drops the read request, abandons a partial fetch and launches nothing. Cancel overrides run bits in the same word. The next start fetches again from word 0.
- R11: A run starts only on a write to offset 0x1C with bit 0 (run) and bit 4 (list) both set and bit 20 clear. Any other control value, and any write to another offset, starts nothing.
- R12: A write to offset 0x14 sets the head address used by the next start and does not disturb a run in progress. A start write while a run is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_ofs | input | 6 | Byte offset in the channel window (0x14 head, 0x1C control) |
| cfg_wr_data | input | 32 | Register write data |
| mem_rd_req | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 32 | Descriptor word byte address |
| mem_rd_valid | input | 1 | Read data valid; accepts the current word |
| mem_rd_data | input | 32 | Read data |
| xfer_start | output | 1 | One-cycle launch pulse to the datapath |
| xfer_bytes | output | 25 | Byte count of the current command |
| xfer_src | output | 32 | Read address of the current command |
| xfer_dst | output | 32 | Write address of the current command |
| xfer_gen_cfg | output | 32 | General configuration word of the current command |
| xfer_port_cfg | output | 32 | Read-port configuration word of the current command |
| xfer_done | input | 1 | Datapath completion of the current command |
| evt_loaded | output | 1 | List-loaded event pulse |
| evt_cmd_done | output | 1 | Command-completed event pulse |

## Verification
Single-descriptor runs come from a table that varies the head address, field values and the size word. The table includes the smallest and largest counts and a size word with junk in its top byte. Memory responds either every cycle or every other cycle, which separates advancing on valid from advancing on request. A two-node chain shows that the link is followed and that the loaded event is not repeated. A two-node ring, cancelled while waiting, shows endless repetition and the cancel path. Cancelling during a stalled fetch, writing malformed control words, and rewriting the head mid-run show that each such write is either ignored or takes effect only at the next start.

// File: rtl/dma_chain_walker_pkg.sv
package dma_chain_walker_pkg;

    // Descriptor layout: word count and position of each decoded word
    localparam int DESC_WORDS = 8;
    localparam int WORD_BYTES = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    localparam int WIX_GEN  = 0;
    localparam int WIX_PORT = 1;
    localparam int WIX_SRC  = 2;
    localparam int WIX_DST  = 3;
    localparam int WIX_SIZE = 4;
    localparam int WIX_LINK = 5;

    // Channel window offsets
    localparam logic [5:0] OFS_HEAD = 6'h14;
    localparam logic [5:0] OFS_CTRL = 6'h1C;

    // Control word bit positions
    localparam int CTL_RUN_BIT   = 0;
    localparam int CTL_LIST_BIT  = 4;
    localparam int CTL_ABORT_BIT = 20;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_LAUNCH = 2'd2,
        ST_WAIT   = 2'd3
    } walk_state_t;

endpackage

// File: rtl/dma_chain_walker_regs.sv
module dma_chain_walker_regs
    import dma_chain_walker_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] head_ptr,
    output logic              start_req,
    output logic              cancel_req
);

    logic hit_head;
    logic hit_ctrl;

    assign hit_head = wr_en && (wr_ofs == OFS_W'(OFS_HEAD));
    assign hit_ctrl = wr_en && (wr_ofs == OFS_W'(OFS_CTRL));

    // Cancel always wins over the run bits of the same word
    assign cancel_req = hit_ctrl && wr_data[CTL_ABORT_BIT];
    assign start_req  = hit_ctrl && wr_data[CTL_RUN_BIT] && wr_data[CTL_LIST_BIT]
                        && !wr_data[CTL_ABORT_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
        end else if (hit_head) begin
            head_ptr <= wr_data[ADDR_W-1:0];
        end
    end

endmodule

// File: rtl/dma_chain_walker_fetch.sv
module dma_chain_walker_fetch
    import dma_chain_walker_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_go,
    input  logic              abort,
    input  logic [ADDR_W-1:0] node_ptr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              last_word,
    output logic [DATA_W-1:0] gen_q,
    output logic [DATA_W-1:0] port_q,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [SIZE_W-1:0] size_q,
    output logic [ADDR_W-1:0] link_q
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    logic [IDX_W-1:0] idx;
    logic             take;

    assign take      = fetch_go && !abort && rd_valid;
    assign last_word = take && (idx == LAST_IDX);
    assign rd_addr   = node_ptr + ADDR_W'(idx) * ADDR_W'(WORD_BYTES);

    // Word counter: restarts whenever the sequencer leaves FETCH or aborts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (!fetch_go || abort) begin
            idx <= '0;
        end else if (rd_valid) begin
            idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end
    end

    // Context capture; words 6 and 7 are read but not kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q  <= '0;
            port_q <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            size_q <= '0;
            link_q <= '0;
        end else if (take) begin
            case (idx)
                IDX_W'(WIX_GEN):  gen_q  <= rd_data;
                IDX_W'(WIX_PORT): port_q <= rd_data;
                IDX_W'(WIX_SRC):  src_q  <= rd_data[ADDR_W-1:0];
                IDX_W'(WIX_DST):  dst_q  <= rd_data[ADDR_W-1:0];
                IDX_W'(WIX_SIZE): size_q <= rd_data[SIZE_W-1:0];
                IDX_W'(WIX_LINK): link_q <= rd_data[ADDR_W-1:0];
                default: ;
            endcase
        end
    end

    // R2: address held while a word is outstanding
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go && !rd_valid && !abort |=> $stable(rd_addr));

    // R2: address steps one word after each accepted word
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go && rd_valid && !abort && !last_word
        |=> rd_addr == $past(rd_addr) + ADDR_W'(WORD_BYTES));

endmodule

// File: rtl/dma_chain_walker_seq.sv
module dma_chain_walker_seq
    import dma_chain_walker_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              cancel_req,
    input  logic [ADDR_W-1:0] head_ptr,
    input  logic              last_word,
    input  logic [ADDR_W-1:0] link_ptr,
    input  logic              xfer_done,
    output walk_state_t       state,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              mem_rd_req,
    output logic              xfer_start,
    output logic              evt_loaded,
    output logic              evt_cmd_done
);

    walk_state_t state_q;
    walk_state_t state_d;
    logic        first_q;

    assign state = state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_req) state_d = ST_FETCH;
            ST_FETCH:  if (last_word) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_WAIT;
            ST_WAIT:   if (xfer_done) state_d = (link_ptr != '0) ? ST_FETCH : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (cancel_req) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Node pointer and first-launch flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ptr <= '0;
            first_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_req && !cancel_req) begin
                cur_ptr <= head_ptr;
                first_q <= 1'b1;
            end else if (state_q == ST_WAIT && xfer_done && !cancel_req
                         && link_ptr != '0) begin
                cur_ptr <= link_ptr;
            end
            if (state_q == ST_LAUNCH) first_q <= 1'b0;
        end
    end

    always_comb begin
        mem_rd_req   = (state_q == ST_FETCH);
        xfer_start   = (state_q == ST_LAUNCH);
        evt_loaded   = (state_q == ST_LAUNCH) && first_q;
        evt_cmd_done = (state_q == ST_WAIT) && xfer_done && !cancel_req;
    end

    p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    p_loaded_at_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_loaded |-> xfer_start);

    p_cancel_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_req |=> !mem_rd_req && !xfer_start);

    p_done_in_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cmd_done |-> xfer_done);

endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
    import dma_chain_walker_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 6,
    parameter int SIZE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [OFS_W-1:0]  cfg_wr_ofs,
    input  logic [DATA_W-1:0] cfg_wr_data,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              xfer_start,
    output logic [SIZE_W:0]   xfer_bytes,
    output logic [ADDR_W-1:0] xfer_src,
    output logic [ADDR_W-1:0] xfer_dst,
    output logic [DATA_W-1:0] xfer_gen_cfg,
    output logic [DATA_W-1:0] xfer_port_cfg,
    input  logic              xfer_done,
    output logic              evt_loaded,
    output logic              evt_cmd_done
);

    logic [ADDR_W-1:0] head_ptr;
    logic              start_req;
    logic              cancel_req;
    logic              last_word;
    logic [ADDR_W-1:0] link_ptr;
    logic [ADDR_W-1:0] cur_ptr;
    logic [SIZE_W-1:0] size_q;
    walk_state_t       state;

    dma_chain_walker_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_ofs     (cfg_wr_ofs),
        .wr_data    (cfg_wr_data),
        .head_ptr   (head_ptr),
        .start_req  (start_req),
        .cancel_req (cancel_req)
    );

    dma_chain_walker_seq #(
        .ADDR_W(ADDR_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .cancel_req   (cancel_req),
        .head_ptr     (head_ptr),
        .last_word    (last_word),
        .link_ptr     (link_ptr),
        .xfer_done    (xfer_done),
        .state        (state),
        .cur_ptr      (cur_ptr),
        .mem_rd_req   (mem_rd_req),
        .xfer_start   (xfer_start),
        .evt_loaded   (evt_loaded),
        .evt_cmd_done (evt_cmd_done)
    );

    dma_chain_walker_fetch #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_go  (state == ST_FETCH),
        .abort     (cancel_req),
        .node_ptr  (cur_ptr),
        .rd_valid  (mem_rd_valid),
        .rd_data   (mem_rd_data),
        .rd_addr   (mem_rd_addr),
        .last_word (last_word),
        .gen_q     (xfer_gen_cfg),
        .port_q    (xfer_port_cfg),
        .src_q     (xfer_src),
        .dst_q     (xfer_dst),
        .size_q    (size_q),
        .link_q    (link_ptr)
    );

    // Stored count is bytes minus one
    assign xfer_bytes = (SIZE_W+1)'(size_q) + 1'b1;

endmodule

// File: tb/dma_chain_walker_test.sv
`timescale 1ns/1ps
module dma_chain_walker_test;

    typedef struct packed {
        logic [31:0] head;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] size_word;
        logic [31:0] exp_bytes;
        logic        stall;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{32'h0000_0100, 32'h1000_0000, 32'h2000_0004, 32'h0000_0000, 32'h0000_0001, 1'b0},
        '{32'h0000_0140, 32'hA5A5_0000, 32'h0000_0040, 32'h00FF_FFFF, 32'h0100_0000, 1'b1},
        '{32'h0000_0200, 32'h1234_5678, 32'h8765_4320, 32'hFF00_0010, 32'h0000_0011, 1'b0},
        '{32'h0000_03E0, 32'h0000_0000, 32'hFFFF_FFFC, 32'h0000_07FF, 32'h0000_0800, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [5:0]  cfg_wr_ofs = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        xfer_start;
    logic [24:0] xfer_bytes;
    logic [31:0] xfer_src, xfer_dst, xfer_gen_cfg, xfer_port_cfg;
    logic        xfer_done = 1'b0;
    logic        evt_loaded, evt_cmd_done;

    dma_chain_walker uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_ofs(cfg_wr_ofs), .cfg_wr_data(cfg_wr_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .xfer_start(xfer_start), .xfer_bytes(xfer_bytes),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_gen_cfg(xfer_gen_cfg), .xfer_port_cfg(xfer_port_cfg),
        .xfer_done(xfer_done), .evt_loaded(evt_loaded), .evt_cmd_done(evt_cmd_done)
    );

    always #2.5 clk = ~clk;

    logic [31:0] mem [0:255];
    logic [31:0] rd_log [0:1023];
    int rd_cnt = 0, start_cnt = 0, loaded_cnt = 0, done_cnt = 0, req_cyc = 0;
    logic stall_en = 1'b0, stall_ph = 1'b0;
    logic [31:0] cap_src, cap_dst, cap_gen, cap_port, cap_bytes;
    int checks = 0, errors = 0;
    bit finished = 0;

    // Memory responder: drives valid/data at the falling edge
    always @(negedge clk) begin
        if (mem_rd_req && !(stall_en && stall_ph)) begin
            mem_rd_valid = 1'b1;
            mem_rd_data  = mem[mem_rd_addr[9:2]];
            rd_log[rd_cnt[9:0]] = mem_rd_addr;
            rd_cnt++;
        end else begin
            mem_rd_valid = 1'b0;
        end
        stall_ph = ~stall_ph;
    end

    // Output monitor, sampled after inputs settle
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (xfer_start) begin
                start_cnt++;
                cap_src = xfer_src; cap_dst = xfer_dst;
                cap_gen = xfer_gen_cfg; cap_port = xfer_port_cfg;
                cap_bytes = 32'(xfer_bytes);
            end
            if (evt_loaded)   loaded_cnt++;
            if (evt_cmd_done) done_cnt++;
            if (mem_rd_req)   req_cyc++;
        end
    end

    task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(logic [5:0] ofs, logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_ofs = ofs; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic start_run(logic [31:0] head);
        cfg_write(6'h14, head);
        cfg_write(6'h1C, 32'h0000_0011);
    endtask

    task automatic finish_cmd();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic wait_starts(int target, string rq);
        int k = 0;
        while (start_cnt < target && k < 400) begin
            @(negedge clk);
            k++;
        end
        check(rq, "launch seen", 32'(start_cnt >= target), 32'd1);
    endtask

    task automatic put_desc(logic [31:0] a, logic [31:0] g, logic [31:0] p,
                            logic [31:0] s, logic [31:0] d, logic [31:0] sz,
                            logic [31:0] nx);
        mem[a[9:2] + 0] = g;  mem[a[9:2] + 1] = p;
        mem[a[9:2] + 2] = s;  mem[a[9:2] + 3] = d;
        mem[a[9:2] + 4] = sz; mem[a[9:2] + 5] = nx;
        mem[a[9:2] + 6] = 32'hDEAD_0006; mem[a[9:2] + 7] = 32'h0000_0011;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int rb, sb, lb, db, rq;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        tick(3);
        #1;
        check("R1", "req in reset", 32'(mem_rd_req), 0);
        check("R1", "start in reset", 32'(xfer_start), 0);
        check("R1", "events in reset", 32'({evt_loaded, evt_cmd_done}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick(2);
        check("R1", "quiet after reset", 32'({mem_rd_req, xfer_start, evt_loaded, evt_cmd_done}), 0);

        // Table-driven single-descriptor runs
        for (int i = 0; i < 4; i++) begin
            vec_t v = VECS[i];
            stall_en = v.stall;
            put_desc(v.head, 32'hC0DE_0000 | 32'(i), 32'h0000_1100 + 32'(i),
                     v.src, v.dst, v.size_word, 32'h0);
            rb = rd_cnt; sb = start_cnt; lb = loaded_cnt; db = done_cnt;
            start_run(v.head);
            wait_starts(sb + 1, "R5");
            check("R2", "word reads", 32'(rd_cnt - rb), 8);
            for (int k = 0; k < 8; k++)
                check("R2", "word addr", rd_log[rb + k], v.head + 32'(4 * k));
            check("R3", "src", cap_src, v.src);
            check("R3", "dst", cap_dst, v.dst);
            check("R3", "gen cfg", cap_gen, 32'hC0DE_0000 | 32'(i));
            check("R3", "port cfg", cap_port, 32'h0000_1100 + 32'(i));
            check("R4", "bytes", cap_bytes, v.exp_bytes);
            check("R5", "loaded event", 32'(loaded_cnt - lb), 1);
            check("R5", "single launch", 32'(start_cnt - sb), 1);
            finish_cmd();
            tick(4);
            check("R6", "cmd event", 32'(done_cnt - db), 1);
            check("R8", "no refetch", 32'(rd_cnt - rb), 8);
            finish_cmd();
            tick(2);
            check("R8", "stray done ignored", 32'(done_cnt - db), 1);
        end
        stall_en = 1'b0;

        // R7: two-node chain
        put_desc(32'h080, 32'h1, 32'h2, 32'hAAAA_0000, 32'h1, 32'h3, 32'h0C0);
        put_desc(32'h0C0, 32'h1, 32'h2, 32'hBBBB_0000, 32'h1, 32'h3, 32'h0);
        rb = rd_cnt; sb = start_cnt; lb = loaded_cnt; db = done_cnt;
        start_run(32'h080);
        wait_starts(sb + 1, "R7");
        check("R7", "first src", cap_src, 32'hAAAA_0000);
        finish_cmd();
        wait_starts(sb + 2, "R7");
        check("R7", "second src", cap_src, 32'hBBBB_0000);
        check("R7", "link fetch addr", rd_log[rb + 8], 32'h0C0);
        check("R5", "loaded once in chain", 32'(loaded_cnt - lb), 1);
        finish_cmd();
        tick(4);
        check("R6", "two cmd events", 32'(done_cnt - db), 2);
        check("R8", "chain reads", 32'(rd_cnt - rb), 16);

        // R9: ring of two, then cancel while waiting (R10)
        put_desc(32'h040, 32'h1, 32'h2, 32'hCCCC_0000, 32'h1, 32'h3, 32'h060);
        put_desc(32'h060, 32'h1, 32'h2, 32'hDDDD_0000, 32'h1, 32'h3, 32'h040);
        rb = rd_cnt; sb = start_cnt; lb = loaded_cnt; db = done_cnt;
        start_run(32'h040);
        for (int k = 0; k < 3; k++) begin
            wait_starts(sb + k + 1, "R9");
            finish_cmd();
        end
        wait_starts(sb + 4, "R9");
        check("R9", "fourth src", cap_src, 32'hDDDD_0000);
        check("R9", "ring back to head", rd_log[rb + 16], 32'h040);
        check("R9", "loaded once", 32'(loaded_cnt - lb), 1);
        cfg_write(6'h1C, 32'h0010_0000);
        finish_cmd();
        tick(4);
        check("R10", "done after cancel ignored", 32'(done_cnt - db), 3);
        check("R10", "no reads after cancel", 32'(rd_cnt - rb), 32);
        check("R10", "no launch after cancel", 32'(start_cnt - sb), 4);

        // R10: cancel during a stalled fetch, then restart
        stall_en = 1'b1;
        sb = start_cnt;
        start_run(32'h100);
        tick(3);
        cfg_write(6'h1C, 32'h0010_0011);
        rq = req_cyc;
        tick(8);
        check("R10", "request dropped", 32'(req_cyc - rq), 0);
        check("R10", "no launch", 32'(start_cnt - sb), 0);
        stall_en = 1'b0;
        rb = rd_cnt;
        start_run(32'h100);
        wait_starts(sb + 1, "R10");
        check("R10", "restart at word 0", rd_log[rb], 32'h100);
        check("R10", "full refetch", 32'(rd_cnt - rb), 8);
        finish_cmd();
        tick(3);

        // R11: malformed control writes
        sb = start_cnt; rq = req_cyc;
        cfg_write(6'h1C, 32'h0000_0010); tick(4);
        cfg_write(6'h1C, 32'h0000_0001); tick(4);
        cfg_write(6'h1C, 32'h0010_0011); tick(4);
        cfg_write(6'h18, 32'h0000_0011); tick(4);
        check("R11", "no fetch", 32'(req_cyc - rq), 0);
        check("R11", "no launch", 32'(start_cnt - sb), 0);

        // R12: head rewrite and start during a run
        rb = rd_cnt; sb = start_cnt;
        start_run(32'h100);
        wait_starts(sb + 1, "R12");
        cfg_write(6'h14, 32'h200);
        cfg_write(6'h1C, 32'h0000_0011);
        finish_cmd();
        tick(4);
        check("R12", "run unchanged", 32'(rd_cnt - rb), 8);
        check("R12", "busy start ignored", 32'(start_cnt - sb), 1);
        rb = rd_cnt;
        cfg_write(6'h1C, 32'h0000_0011);
        wait_starts(sb + 2, "R12");
        check("R12", "new head used", rd_log[rb], 32'h200);
        finish_cmd();
        tick(3);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule